// File: doc/BRIEF.md
# Fetch-Tracking Single-Screen Page Selector

This block picks which of two single-screen nametable pages the video side should use, and it makes that choice from the character banking rather than from a programmed mirroring register. The character space is split into eight 1 KB slots. Each time a bank value is assigned to a slot, the block keeps only the top bit of that value (bit 7) in a one-bit cache entry for the slot.

The video fetch unit presents every pattern fetch address with a valid strobe. The block masks the address to its low 13 bits and takes bits 12:10 as the current slot. The page-select output then follows the cached bit of that slot. If a bank update lands on the slot that is currently selected, the output takes the new bit at once. The bank values themselves come from elsewhere. This block only watches the update port.

Top module: `mirror_page_select`

## Requirements
- R1: After reset every cached slot bit, the current slot and `page_sel` are 0. A fetch to any slot before any bank update gives `page_sel` = 0.
- R2: On a fetch, the current slot is bits 12:10 of `pat_addr`. Bits above bit 12 and bits below bit 10 have no effect on the slot chosen.
- R3: The clock edge that accepts a fetch (`pat_vld` = 1) sets `page_sel` to the cached bit of the newly addressed slot. The value 0 selects page 0 and the value 1 selects page 1.
- R4: A bank update (`bank_wr` = 1) to the slot that is currently selected, with no fetch in that cycle, sets `page_sel` to bit 7 of `bank_val` on the same clock edge.
- R5: A bank update to a slot other than the current one leaves `page_sel` unchanged. It still stores bit 7 of `bank_val` for that slot, and a later fetch of that slot shows the stored bit.
- R6: Only bit 7 of `bank_val` is stored. Bits 6:0 have no effect on the output.
- R7: When a bank update and a fetch happen in the same cycle, the fetch picks its slot from the cache as already updated by that write.
- R8: With neither `bank_wr` nor `pat_vld` asserted, `page_sel` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_wr | input | 1 | Bank update strobe |
| bank_slot | input | 3 | Character slot index of the update |
| bank_val | input | 8 | Bank value assigned to the slot (bit 7 is used) |
| pat_vld | input | 1 | Pattern fetch strobe |
| pat_addr | input | 16 | Pattern fetch address |
| page_sel | output | 1 | Single-screen page select (0 = page 0, 1 = page 1) |

## Verification
The properties assume the strobes are never unknown, and that `bank_slot` and `pat_addr` are meaningful only while their strobes are high. The stimulus drives every input away from the clock edge, and it also drives arbitrary address and bank bits in cycles where the strobe is low, so the properties also see inputs that must be ignored. Directed cycles cover simultaneous update and fetch to the same slot and to different slots, addresses with bits set above bit 12, and bank values that differ only below bit 7. A long run of random strobes and values then compares the output against the reference model on every clock.

// File: rtl/mps_pkg.sv
package mps_pkg;
  parameter int DEF_SLOTS      = 8;
  parameter int DEF_BANK_W     = 8;
  parameter int DEF_ADDR_W     = 16;
  parameter int DEF_SLOT_SHIFT = 10;
  parameter int DEF_PAGE_BIT   = 7;
endpackage

// File: rtl/mps_bit_cache.sv
module mps_bit_cache #(
  parameter int SLOTS    = 8,
  parameter int BANK_W   = 8,
  parameter int PAGE_BIT = 7,
  localparam int IDX_W   = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BANK_W-1:0] wr_val,
  output logic [SLOTS-1:0]  bits_q,
  output logic [SLOTS-1:0]  bits_d
);
  localparam logic [BANK_W-1:0] PAGE_MASK = BANK_W'(1) << PAGE_BIT;

  logic new_bit;
  assign new_bit = |(wr_val & PAGE_MASK);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      bits_d[g] = bits_q[g];
      if (hit) bits_d[g] = new_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bits_q[g] <= 1'b0;
      else if (hit) bits_q[g] <= bits_d[g];
    end
  end
endmodule

// File: rtl/mps_slot_tracker.sv
module mps_slot_tracker #(
  parameter int ADDR_W     = 16,
  parameter int SLOT_SHIFT = 10,
  parameter int IDX_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_vld,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [IDX_W-1:0]  slot_q,
  output logic [IDX_W-1:0]  slot_d
);
  localparam int WIN_W = SLOT_SHIFT + IDX_W;
  localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'((64'd1 << WIN_W) - 64'd1);

  logic [ADDR_W-1:0] masked;
  assign masked = (fetch_addr & WIN_MASK) >> SLOT_SHIFT;

  always_comb begin
    slot_d = slot_q;
    if (fetch_vld) slot_d = IDX_W'(masked);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         slot_q <= '0;
    else if (fetch_vld) slot_q <= slot_d;
  end
endmodule

// File: rtl/mps_page_reg.sv
module mps_page_reg #(
  parameter int SLOTS  = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [SLOTS-1:0] bits_d,
  input  logic [IDX_W-1:0] slot_d,
  output logic             page_q
);
  logic page_d;

  always_comb begin
    page_d = page_q;
    if (upd_en) page_d = bits_d[slot_d];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      page_q <= 1'b0;
    else if (upd_en) page_q <= page_d;
  end
endmodule

// File: rtl/mirror_page_select.sv
module mirror_page_select
  import mps_pkg::*;
#(
  parameter int SLOTS      = DEF_SLOTS,
  parameter int BANK_W     = DEF_BANK_W,
  parameter int ADDR_W     = DEF_ADDR_W,
  parameter int SLOT_SHIFT = DEF_SLOT_SHIFT,
  parameter int PAGE_BIT   = DEF_PAGE_BIT,
  localparam int IDX_W     = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_wr,
  input  logic [IDX_W-1:0]  bank_slot,
  input  logic [BANK_W-1:0] bank_val,
  input  logic              pat_vld,
  input  logic [ADDR_W-1:0] pat_addr,
  output logic              page_sel
);
  logic [SLOTS-1:0] bits_q;
  logic [SLOTS-1:0] bits_d;
  logic [IDX_W-1:0] slot_q;
  logic [IDX_W-1:0] slot_d;
  logic             any_evt;

  assign any_evt = bank_wr | pat_vld;

  mps_bit_cache #(
    .SLOTS(SLOTS), .BANK_W(BANK_W), .PAGE_BIT(PAGE_BIT)
  ) u_cache (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bank_wr), .wr_idx(bank_slot), .wr_val(bank_val),
    .bits_q(bits_q), .bits_d(bits_d)
  );

  mps_slot_tracker #(
    .ADDR_W(ADDR_W), .SLOT_SHIFT(SLOT_SHIFT), .IDX_W(IDX_W)
  ) u_track (
    .clk(clk), .rst_n(rst_n),
    .fetch_vld(pat_vld), .fetch_addr(pat_addr),
    .slot_q(slot_q), .slot_d(slot_d)
  );

  mps_page_reg #(
    .SLOTS(SLOTS)
  ) u_page (
    .clk(clk), .rst_n(rst_n),
    .upd_en(any_evt), .bits_d(bits_d), .slot_d(slot_d),
    .page_q(page_sel)
  );

  logic unused_bits_q;
  assign unused_bits_q = ^bits_q;
endmodule

// File: rtl/mps_checker.sv
module mps_checker #(
  parameter int SLOTS      = 8,
  parameter int BANK_W     = 8,
  parameter int ADDR_W     = 16,
  parameter int SLOT_SHIFT = 10,
  parameter int PAGE_BIT   = 7,
  localparam int IDX_W     = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bank_wr,
  input logic [IDX_W-1:0]  bank_slot,
  input logic [BANK_W-1:0] bank_val,
  input logic              pat_vld,
  input logic [ADDR_W-1:0] pat_addr,
  input logic              page_sel,
  input logic [IDX_W-1:0]  cur_slot
);
  localparam int WIN_W = SLOT_SHIFT + IDX_W;
  localparam logic [ADDR_W-1:0] WIN_MASK  = ADDR_W'((64'd1 << WIN_W) - 64'd1);
  localparam logic [BANK_W-1:0] PAGE_MASK = BANK_W'(1) << PAGE_BIT;

  logic [ADDR_W-1:0] win;
  logic [IDX_W-1:0]  fetch_slot;
  logic              wr_bit;
  assign win        = (pat_addr & WIN_MASK) >> SLOT_SHIFT;
  assign fetch_slot = IDX_W'(win);
  assign wr_bit     = |(bank_val & PAGE_MASK);

  // R2: the tracked slot follows the masked fetch address
  p_slot_from_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pat_vld |=> cur_slot == $past(fetch_slot));

  // R4: an update to the live slot shows up at once
  p_live_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr && !pat_vld && bank_slot == cur_slot) |=> page_sel == $past(wr_bit));

  // R5: an update elsewhere leaves the output alone
  p_other_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr && !pat_vld && bank_slot != cur_slot) |=> $stable(page_sel));

  // R7: a same-cycle update and fetch to one slot yields the new bit
  p_same_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr && pat_vld && bank_slot == fetch_slot) |=> page_sel == $past(wr_bit));

  // R8: no strobe, no change
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_wr && !pat_vld) |=> $stable(page_sel));

  // R1: the tracked slot is zero while reset is held
  always_comb begin
    if (!rst_n) begin
      p_reset_slot_r1: assert (cur_slot == '0);
    end
  end
endmodule

bind mirror_page_select mps_checker #(
  .SLOTS(SLOTS), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
  .SLOT_SHIFT(SLOT_SHIFT), .PAGE_BIT(PAGE_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bank_wr(bank_wr), .bank_slot(bank_slot), .bank_val(bank_val),
  .pat_vld(pat_vld), .pat_addr(pat_addr),
  .page_sel(page_sel), .cur_slot(slot_q)
);

// File: tb/mirror_page_select_test.sv
module mirror_page_select_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bank_wr;
  logic [2:0]  bank_slot;
  logic [7:0]  bank_val;
  logic        pat_vld;
  logic [15:0] pat_addr;
  logic        page_sel;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  // behavioural reference state
  bit  ref_cache[8];
  int  ref_slot;
  bit  ref_page;

  always #10 clk = ~clk;

  mirror_page_select uut (
    .clk(clk), .rst_n(rst_n),
    .bank_wr(bank_wr), .bank_slot(bank_slot), .bank_val(bank_val),
    .pat_vld(pat_vld), .pat_addr(pat_addr),
    .page_sel(page_sel)
  );

  task automatic compare(input string tag);
    checks++;
    if (page_sel !== ref_page) begin
      errors++;
      $display("FAIL %s: page_sel=%0b expected=%0b at %0t", tag, page_sel, ref_page, $time);
    end
  endtask

  // one clock: drive at the falling edge, update the model at the rising edge,
  // compare at the next falling edge
  task automatic cyc(input bit wr, input int slot, input int val,
                     input bit fv, input int addr, input string tag);
    bank_wr   = wr;
    bank_slot = 3'(slot);
    bank_val  = 8'(val);
    pat_vld   = fv;
    pat_addr  = 16'(addr);
    @(posedge clk);
    if (wr) ref_cache[slot & 7] = ((val >> 7) & 1) != 0;
    if (fv) ref_slot = (addr % 8192) / 1024;
    if (wr || fv) ref_page = ref_cache[ref_slot];
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bank_wr = 1'b0; bank_slot = '0; bank_val = '0;
    pat_vld = 1'b0; pat_addr = '0;
    foreach (ref_cache[i]) ref_cache[i] = 1'b0;
    ref_slot = 0; ref_page = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // R1: every slot reads 0 before any update
    for (int s = 0; s < 8; s++) cyc(1'b0, 0, 0, 1'b1, s * 1024 + 5, "R1 clean slot");

    // back to slot 0, then update slot 3 while slot 0 is live
    cyc(1'b0, 0, 0, 1'b1, 16'h0000, "R3 fetch slot0");
    cyc(1'b1, 3, 8'h80, 1'b0, 16'h0C00, "R5 other-slot update keeps output");
    cyc(1'b0, 0, 0, 1'b1, 16'h0C00, "R3 fetch slot3 shows stored bit");
    cyc(1'b0, 0, 0, 1'b1, 16'h0000, "R3 fetch slot0 back to 0");
    cyc(1'b0, 0, 0, 1'b1, 16'hEC00, "R2 high address bits ignored");
    cyc(1'b0, 0, 0, 1'b1, 16'h2400, "R2 masking maps 0x2400 to slot1");
    cyc(1'b0, 0, 0, 1'b1, 16'h0FFF, "R2 low bits ignored slot3");
    cyc(1'b0, 0, 0, 1'b1, 16'h07FF, "R2 slot1 top address");

    // live-slot updates (slot 1)
    cyc(1'b1, 1, 8'h7F, 1'b0, 16'h0000, "R6 low bits of bank ignored");
    cyc(1'b1, 1, 8'h80, 1'b0, 16'h0000, "R4 live update to 1");
    cyc(1'b1, 1, 8'hFF, 1'b0, 16'h0000, "R4 live update stays 1");
    cyc(1'b1, 1, 8'h00, 1'b0, 16'h0000, "R4 live update to 0");
    cyc(1'b1, 1, 8'hC3, 1'b0, 16'h0000, "R6 only bit7 counts");

    // idle holds
    cyc(1'b0, 5, 8'h00, 1'b0, 16'h1400, "R8 hold with strobes low");
    cyc(1'b0, 1, 8'h00, 1'b0, 16'h0400, "R8 hold ignores bank lines");

    // same-cycle update and fetch
    cyc(1'b1, 5, 8'h80, 1'b1, 16'h1400, "R7 same slot new bit 1");
    cyc(1'b1, 6, 8'hFF, 1'b1, 16'h1BFF, "R7 same slot slot6");
    cyc(1'b1, 6, 8'h00, 1'b1, 16'h1800, "R7 same slot clears");
    cyc(1'b1, 2, 8'h80, 1'b1, 16'h1400, "R7 different slots");
    cyc(1'b0, 0, 0, 1'b1, 16'h0800, "R5 slot2 stored during fetch");

    // random traffic compared every clock
    for (int n = 0; n < 2000; n++) begin
      cyc(1'($urandom_range(0, 1)), int'($urandom_range(0, 7)), int'($urandom_range(0, 255)),
          1'($urandom_range(0, 1)), int'($urandom_range(0, 65535)), "R3 random traffic");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule